// File: doc/BRIEF.md
# Mode-0 Parallel Port Group with Gated Output Buffers

This block is a 24-bit register-mapped parallel I/O group with three 8-bit ports, A, B and C. Port C is split into two 4-bit halves, and each half has its own direction. Each port, or each half of port C, is set as input or output through a control register. Every port works in the plain latched-output and transparent-input mode. A write to an output port loads that port's latch, and the latch drives the pad data lines. A read of an input port returns the live pin values.

The top bit of a control write has two meanings. When it is set, the write loads new direction and mode bits and switches every pad driver off. When it is clear, the write only switches the drivers back on and leaves the direction bits alone. Software can therefore write the new directions, stage the output values while the pads are still in high impedance, and then open all the drivers with a single write. A static strap input, when high, keeps the drivers on no matter what state the gating latch is in.

Top module: `pio_group`

## Requirements
- R1: Reset state. Every port and half-port is an input, and the drivers are gated off, so `pin_oe` is 0. The output latches are 0x00, and the control readback at address 3 is 0x9B.
- R2: A write to address 3 with data bit 7 = 1 does two things. It loads data bits 6:0 as the new configuration, and it gates all drivers off.
- R3: A write to address 3 with data bit 7 = 0 clears the gating latch so the drivers turn on. It leaves the configuration bits unchanged.
- R4: The direction bits in the configuration are: bit 4 for port A (`pin_*[7:0]`), bit 1 for port B (`[15:8]`), bit 3 for port C high (`[23:20]`) and bit 0 for port C low (`[19:16]`). A value of 1 means input. A pin's `pin_oe` is 1 only when its group is an output and the drivers are on.
- R5: Writes to addresses 0, 1 and 2 load the latches of ports A, B and C. This happens even while the drivers are gated off. `pin_out` always shows the latches.
- R6: While `strap_force_en` = 1, the gating latch is ignored, and every pin in an output group has `pin_oe` = 1.
- R7: A read of a port returns the pin value for each bit in an input group, and the latch value for each bit in an output group.
- R8: A read of address 3 returns the stored configuration bits 6:0, with bit 7 showing the gating latch (1 = drivers off).
- R9: The mode-select fields are bit 2 and bits 6:5. They are stored and read back, but they have no effect on the port behaviour.
- R10: A change of direction never alters an output latch.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is high. It is valid after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register address: 0 = A, 1 = B, 2 = C, 3 = control |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| strap_force_en | input | 1 | Static strap that keeps the drivers on |
| pin_in | input | 24 | Pin sample values: C, B, A from MSB to LSB |
| pin_out | output | 24 | Output latch values for the pads |
| pin_oe | output | 24 | Per-bit pad output enable |

## Verification
The assertions assume three things about the inputs. First, `bus_wr` and `bus_rd` are never high in the same cycle. Second, the address and write data are valid whenever a strobe is high. Third, `strap_force_en` only changes while the bus is idle. The bench drives each strobe for one cycle at a falling edge and releases it at the next falling edge. It changes the pins and the strap only between transfers. The pin pattern is chosen so that every nibble differs from the latch contents, so a read from the wrong source shows up in the data.

// File: rtl/pio_pkg.sv
package pio_pkg;
    parameter int PORT_W   = 8;
    parameter int NUM_PORT = 3;
    localparam int BUS_W   = PORT_W * NUM_PORT;
    localparam int HALF_W  = PORT_W / 2;
    localparam int CFG_W   = 7;

    // Register addresses
    localparam logic [1:0] ADR_A    = 2'd0;
    localparam logic [1:0] ADR_B    = 2'd1;
    localparam logic [1:0] ADR_C    = 2'd2;
    localparam logic [1:0] ADR_CTRL = 2'd3;

    // Direction bit positions within the configuration field
    localparam int DIR_CLO = 0;
    localparam int DIR_B   = 1;
    localparam int DIR_CHI = 3;
    localparam int DIR_A   = 4;

    // Reset: every group input, mode fields zero
    localparam logic [CFG_W-1:0] CFG_RESET =
        CFG_W'((1 << DIR_CLO) | (1 << DIR_B) | (1 << DIR_CHI) | (1 << DIR_A));

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             gate_off;
    } ctrl_state_t;

    // Configuration bit that steers a given pad bit
    function automatic int dir_bit_of(input int pin);
        int port;
        int sub;
        port = pin / PORT_W;
        sub  = pin % PORT_W;
        if (port == 0)           return DIR_A;
        else if (port == 1)      return DIR_B;
        else if (sub < HALF_W)   return DIR_CLO;
        else                     return DIR_CHI;
    endfunction
endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             strap_force_en,
    output logic [CFG_W-1:0] cfg,
    output logic             gate_off,
    output logic             drv_en
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            if (ctrl_wdata[7]) begin
                st_d.cfg      = ctrl_wdata[CFG_W-1:0];
                st_d.gate_off = 1'b1;
            end else begin
                st_d.gate_off = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg      <= CFG_RESET;
            st_q.gate_off <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign gate_off = st_q.gate_off;
    assign drv_en   = strap_force_en | ~st_q.gate_off;
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) val_d = load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  logic [BUS_W-1:0] latch_vals,
    input  logic [BUS_W-1:0] pin_vals,
    input  logic [BUS_W-1:0] pin_is_in,
    input  logic [CFG_W-1:0] cfg,
    input  logic             gate_off,
    output logic [7:0]       rdata
);
    logic [BUS_W-1:0] merged;
    logic [7:0]       rd_d, rd_q;

    always_comb begin
        merged = (pin_vals & pin_is_in) | (latch_vals & ~pin_is_in);
        rd_d   = rd_q;
        if (rd_en) begin
            case (rd_addr)
                ADR_A:   rd_d = merged[0*PORT_W +: PORT_W];
                ADR_B:   rd_d = merged[1*PORT_W +: PORT_W];
                ADR_C:   rd_d = merged[2*PORT_W +: PORT_W];
                default: rd_d = {gate_off, cfg};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic        strap_force_en,
    input  logic [23:0] pin_in,
    output logic [23:0] pin_out,
    output logic [23:0] pin_oe
);
    logic [CFG_W-1:0] cfg;
    logic             gate_off;
    logic             drv_en;
    logic [BUS_W-1:0] latch_vals;
    logic [BUS_W-1:0] pin_is_in;

    pio_ctrl_reg u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr        (bus_wr && (bus_addr == ADR_CTRL)),
        .ctrl_wdata     (bus_wdata),
        .strap_force_en (strap_force_en),
        .cfg            (cfg),
        .gate_off       (gate_off),
        .drv_en         (drv_en)
    );

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        pio_out_latch #(.W(PORT_W)) u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (bus_wr && (bus_addr == 2'(p))),
            .load_data (bus_wdata[PORT_W-1:0]),
            .q         (latch_vals[p*PORT_W +: PORT_W])
        );
    end

    for (genvar i = 0; i < BUS_W; i++) begin : g_dir
        localparam int DB = dir_bit_of(i);
        assign pin_is_in[i] = cfg[DB];
        assign pin_oe[i]    = ~cfg[DB] & drv_en;
    end

    pio_read_mux u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (bus_rd),
        .rd_addr    (bus_addr),
        .latch_vals (latch_vals),
        .pin_vals   (pin_in),
        .pin_is_in  (pin_is_in),
        .cfg        (cfg),
        .gate_off   (gate_off),
        .rdata      (bus_rdata)
    );

    assign pin_out = latch_vals;
endmodule

// File: rtl/pio_group_chk.sv
module pio_group_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic        strap_force_en,
    input logic [23:0] pin_out,
    input logic [23:0] pin_oe,
    input logic [23:0] pin_is_in
);
    logic ctrl_hi, ctrl_lo;
    assign ctrl_hi = bus_wr && bus_addr == 2'd3 &&  bus_wdata[7];
    assign ctrl_lo = bus_wr && bus_addr == 2'd3 && !bus_wdata[7];

    AST_CTRL_HI_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hi |=> (strap_force_en || pin_oe == 24'h0)); // R2

    AST_CTRL_LO_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lo |=> $stable(pin_is_in)); // R3

    AST_OE_GROUPS_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[7:0] == 8'h00 || pin_oe[7:0] == 8'hFF) &&
        (pin_oe[15:8] == 8'h00 || pin_oe[15:8] == 8'hFF) &&
        (pin_oe[19:16] == 4'h0 || pin_oe[19:16] == 4'hF) &&
        (pin_oe[23:20] == 4'h0 || pin_oe[23:20] == 4'hF)); // R4

    AST_PORT_A_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (pin_out[7:0] == $past(bus_wdata))); // R5

    AST_STRAP_DRIVES_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        strap_force_en |-> (pin_oe == ~pin_is_in)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind pio_group pio_group_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_rdata      (bus_rdata),
    .strap_force_en (strap_force_en),
    .pin_out        (pin_out),
    .pin_oe         (pin_oe),
    .pin_is_in      (pin_is_in)
);

// File: tb/pio_group_bench.sv
`timescale 1ns/1ps
module pio_group_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        strap_force_en = 1'b0;
    logic [23:0] pin_in = 24'h9C_5A_A5;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio_group u_pio_group (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .strap_force_en(strap_force_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  addr;
        logic [7:0]  data;
        logic [7:0]  exp_rd;
        logic [23:0] exp_oe;
        logic [3:0]  req;
    } vec_t;

    // Pins: C=9C, B=5A, A=A5
    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 8'h00, 8'h9B, 24'h000000, 4'd1},  // R1 reset readback
        '{1'b0, 2'd3, 8'h80, 8'h00, 24'h000000, 4'd2},  // R2 all out, gated
        '{1'b0, 2'd0, 8'h11, 8'h00, 24'h000000, 4'd5},  // R5 stage A
        '{1'b0, 2'd1, 8'h22, 8'h00, 24'h000000, 4'd5},  // R5 stage B
        '{1'b0, 2'd2, 8'h33, 8'h00, 24'h000000, 4'd5},  // R5 stage C
        '{1'b1, 2'd0, 8'h00, 8'h11, 24'h000000, 4'd7},  // R7 output reads latch
        '{1'b1, 2'd3, 8'h00, 8'h80, 24'h000000, 4'd8},  // R8
        '{1'b0, 2'd3, 8'h00, 8'h00, 24'hFFFFFF, 4'd3},  // R3 open drivers
        '{1'b1, 2'd3, 8'h00, 8'h00, 24'hFFFFFF, 4'd8},  // R8
        '{1'b0, 2'd3, 8'h89, 8'h00, 24'h000000, 4'd2},  // R2 C both in
        '{1'b0, 2'd3, 8'h09, 8'h00, 24'h00FFFF, 4'd4},  // R4
        '{1'b1, 2'd2, 8'h00, 8'h9C, 24'h00FFFF, 4'd7},  // R7 C from pins
        '{1'b1, 2'd3, 8'h00, 8'h09, 24'h00FFFF, 4'd8},  // R8
        '{1'b0, 2'd3, 8'h81, 8'h00, 24'h000000, 4'd2},  // R2 C low in
        '{1'b0, 2'd3, 8'h01, 8'h00, 24'hF0FFFF, 4'd4},  // R4 nibble split
        '{1'b1, 2'd2, 8'h00, 8'h3C, 24'hF0FFFF, 4'd7},  // R7 mixed nibbles
        '{1'b0, 2'd3, 8'hE4, 8'h00, 24'h000000, 4'd9},  // R9 mode bits set
        '{1'b0, 2'd3, 8'h64, 8'h00, 24'hFFFFFF, 4'd9},  // R9
        '{1'b1, 2'd3, 8'h00, 8'h64, 24'hFFFFFF, 4'd9},  // R9 stored
        '{1'b1, 2'd1, 8'h00, 8'h22, 24'hFFFFFF, 4'd9},  // R9 still mode 0
        '{1'b0, 2'd3, 8'h92, 8'h00, 24'h000000, 4'd10}, // R10 A,B in
        '{1'b0, 2'd3, 8'h12, 8'h00, 24'hFF0000, 4'd10}, // R10
        '{1'b1, 2'd0, 8'h00, 8'hA5, 24'hFF0000, 4'd7},  // R7 A from pins
        '{1'b1, 2'd1, 8'h00, 8'h5A, 24'hFF0000, 4'd7},  // R7 B from pins
        '{1'b0, 2'd3, 8'h80, 8'h00, 24'h000000, 4'd10}, // R10 back to out
        '{1'b0, 2'd3, 8'h00, 8'h00, 24'hFFFFFF, 4'd10}, // R10
        '{1'b1, 2'd0, 8'h00, 8'h11, 24'hFFFFFF, 4'd10}, // R10 latch kept
        '{1'b1, 2'd1, 8'h00, 8'h22, 24'hFFFFFF, 4'd10}  // R10 latch kept
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state at the pins
        check("R1 oe", pin_oe, 24'h0);
        check("R1 latches", pin_out, 24'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                do_read(VECS[i].addr);
                check($sformatf("R%0d rdata v%0d", VECS[i].req, i), 24'(bus_rdata), 24'(VECS[i].exp_rd));
            end else begin
                do_write(VECS[i].addr, VECS[i].data);
            end
            check($sformatf("R%0d oe v%0d", VECS[i].req, i), pin_oe, VECS[i].exp_oe);
        end

        // R5: staged values visible, writes land while gated off
        check("R5 pin_out", pin_out, 24'h33_22_11);
        do_write(2'd3, 8'h80);
        do_write(2'd2, 8'h77);
        check("R5 gated write", pin_out, 24'h77_22_11);
        check("R5 still gated", pin_oe, 24'h0);

        // R6: strap overrides the gate
        strap_force_en = 1'b1;
        @(negedge clk);
        check("R6 strap on", pin_oe, 24'hFFFFFF);
        do_write(2'd3, 8'h90);
        check("R6 strap A in", pin_oe, 24'hFFFF00);
        strap_force_en = 1'b0;
        @(negedge clk);
        check("R6 strap off", pin_oe, 24'h0);

        // R11: read data holds between reads
        do_read(2'd0);
        check("R11 first read", 24'(bus_rdata), 24'hA5);
        pin_in[7:0] = 8'h3E;
        repeat (3) @(negedge clk);
        check("R11 held", 24'(bus_rdata), 24'hA5);
        do_read(2'd0);
        check("R11 new read", 24'(bus_rdata), 24'h3E);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rst oe", pin_oe, 24'h0);
        check("R1 rst latches", pin_out, 24'h0);
        check("R1 rst rdata", 24'(bus_rdata), 24'h0);
        rst_n = 1'b1;
        do_read(2'd3);
        check("R1 rst ctrl", 24'(bus_rdata), 24'h9B);
        do_read(2'd1);
        check("R1 rst B input", 24'(bus_rdata), 24'h5A);

        finish_run();
    end
endmodule